// File: doc/BRIEF.md
# Highest Priority Pending Interrupt Selector

This block sits beside one processor and tracks which interrupt sources are currently raised towards it. Each source has a 5-bit priority, where a larger value is more urgent. From the raised sources the block picks one as the next interrupt to present: the one with the greatest priority, and among equal priorities the one with the smallest index. A raised source with priority zero can still be picked.

The pick is held in a cache. Any raise strobe or accepted acknowledge changes the raised set and marks the cache stale. While the cache is stale the block shows `busy_o` and presents no selection. On the next clock edge with no further change, a single-cycle comparison tree over all sources fills the cache again. An acknowledge takes the index shown on `sel_idx_o` and clears that source's raised bit. An acknowledge is only taken while a valid selection is shown.

Top module: `hpi_select`

## Requirements
- R1: After reset no source is raised, `sel_valid_o` is low, `sel_idx_o` reads all ones, `sel_prio_o` reads zero and `busy_o` is low.
- R2: A one on bit k of `raise_i` at a clock edge sets raised bit k, visible on bit k of `pend_o` after that edge. Bits already set stay set.
- R3: Any raise strobe or accepted acknowledge makes `busy_o` high and `sel_valid_o` low after that edge. If no further change follows, the new selection is valid after the next edge.
- R4: The selection is the raised source with the greatest priority. Source k's priority is `prio_i[5k+4:5k]`, unsigned, and larger means more urgent.
- R5: Among raised sources of equal highest priority, the lowest index is selected.
- R6: A raised source with priority 0 is selected when no other source is raised.
- R7: When no source is raised and the cache is fresh, `sel_valid_o` is low, `sel_idx_o` is all ones and `busy_o` is low.
- R8: `ack_i` high at an edge while `sel_valid_o` is high clears the raised bit of the index on `sel_idx_o`.
- R9: `ack_i` while `busy_o` is high, or while nothing is selected, is ignored. The raised set does not change and no recomputation is started.
- R10: When a source is raised and acknowledged at the same edge, its raised bit stays set.
- R11: Priorities are read only while the cache is refilled. A priority change with no raise or acknowledge leaves the shown selection and `sel_prio_o` unchanged.
- R12: While `sel_valid_o` is high, `sel_prio_o` gives the priority of the selected source as read at refill. Otherwise it reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| raise_i | input | 64 | Per-source raise strobes |
| prio_i | input | 320 | Packed 5-bit priorities, source k at bits 5k+4:5k |
| ack_i | input | 1 | Acknowledge of the presented source |
| sel_idx_o | output | 6 | Selected source index, all ones when none |
| sel_valid_o | output | 1 | Selection is valid |
| sel_prio_o | output | 5 | Priority of the selected source |
| busy_o | output | 1 | Cache is stale, recomputation pending |
| pend_o | output | 64 | Raised set |

## Verification
The hardest case to reach from the ports is an acknowledge that lands in the single stale cycle right after a raise. The bench reaches it by pulsing a raise and asserting `ack_i` on the very next cycle. It then checks that the raised set is intact and that the selection settles without a second stale cycle. A raise and an acknowledge of the currently shown source at the same edge are driven the same way. A priority rewrite is also made while the cache is fresh, to show that it has no effect until the next event. Pseudo-random rounds then load many sources with colliding priorities and drain them one acknowledge at a time.

// File: rtl/hpi_pkg.sv
package hpi_pkg;
  localparam int unsigned SRC_N  = 64;
  localparam int unsigned PRIO_W = 5;
endpackage

// File: rtl/hpi_pend.sv
module hpi_pend #(
  parameter int unsigned NUM_SRC = hpi_pkg::SRC_N,
  localparam int unsigned IDX_W  = $clog2(NUM_SRC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] raise_i,
  input  logic               clr_en_i,
  input  logic [IDX_W-1:0]   clr_idx_i,
  output logic [NUM_SRC-1:0] pend_o
);
  logic [NUM_SRC-1:0] clr_mask;

  always_comb begin
    clr_mask = '0;
    if (clr_en_i) clr_mask = NUM_SRC'(1) << clr_idx_i;
  end

  // raise wins over a clear of the same bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_o <= '0;
    else         pend_o <= (pend_o & ~clr_mask) | raise_i;
  end
endmodule

// File: rtl/hpi_tree.sv
module hpi_tree #(
  parameter int unsigned NUM_SRC = hpi_pkg::SRC_N,
  parameter int unsigned PRIO_W  = hpi_pkg::PRIO_W,
  localparam int unsigned IDX_W  = $clog2(NUM_SRC),
  localparam int unsigned LEAVES = 1 << IDX_W,
  localparam int unsigned NODES  = 2 * LEAVES - 1
) (
  input  logic [NUM_SRC-1:0]        req_i,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
  output logic                      found_o,
  output logic [IDX_W-1:0]          idx_o,
  output logic [PRIO_W-1:0]         prio_o
);
  logic              nv [NODES];
  logic [PRIO_W-1:0] np [NODES];
  logic [IDX_W-1:0]  nx [NODES];

  for (genvar j = 0; j < LEAVES; j++) begin : g_leaf
    if (j < NUM_SRC) begin : g_real
      assign nv[LEAVES-1+j] = req_i[j];
      assign np[LEAVES-1+j] = prio_i[j*PRIO_W +: PRIO_W];
      assign nx[LEAVES-1+j] = IDX_W'(j);
    end else begin : g_pad
      assign nv[LEAVES-1+j] = 1'b0;
      assign np[LEAVES-1+j] = '0;
      assign nx[LEAVES-1+j] = '1;
    end
  end

  // left child covers lower indices; right wins only on strictly higher priority
  for (genvar i = 0; i < LEAVES - 1; i++) begin : g_node
    logic take_r;
    assign take_r = nv[2*i+2] && (!nv[2*i+1] || (np[2*i+2] > np[2*i+1]));
    assign nv[i]  = nv[2*i+1] | nv[2*i+2];
    assign np[i]  = take_r ? np[2*i+2] : np[2*i+1];
    assign nx[i]  = take_r ? nx[2*i+2] : nx[2*i+1];
  end

  assign found_o = nv[0];
  assign idx_o   = nx[0];
  assign prio_o  = np[0];
endmodule

// File: rtl/hpi_cache.sv
module hpi_cache #(
  parameter int unsigned NUM_SRC = hpi_pkg::SRC_N,
  parameter int unsigned PRIO_W  = hpi_pkg::PRIO_W,
  localparam int unsigned IDX_W  = $clog2(NUM_SRC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              change_i,
  input  logic              found_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [PRIO_W-1:0] prio_i,
  output logic              fresh_o,
  output logic              found_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [PRIO_W-1:0] prio_o
);
  // empty set at reset: cache starts fresh with nothing found
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fresh_o <= 1'b1;
      found_o <= 1'b0;
      idx_o   <= '1;
      prio_o  <= '0;
    end else if (change_i) begin
      fresh_o <= 1'b0;
    end else if (!fresh_o) begin
      fresh_o <= 1'b1;
      found_o <= found_i;
      idx_o   <= idx_i;
      prio_o  <= prio_i;
    end
  end
endmodule

// File: rtl/hpi_select.sv
module hpi_select #(
  parameter int unsigned NUM_SRC = hpi_pkg::SRC_N,
  parameter int unsigned PRIO_W  = hpi_pkg::PRIO_W,
  localparam int unsigned IDX_W  = $clog2(NUM_SRC)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_SRC-1:0]        raise_i,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
  input  logic                      ack_i,
  output logic [IDX_W-1:0]          sel_idx_o,
  output logic                      sel_valid_o,
  output logic [PRIO_W-1:0]         sel_prio_o,
  output logic                      busy_o,
  output logic [NUM_SRC-1:0]        pend_o
);
  logic              fresh, c_found, t_found, ack_take, change;
  logic [IDX_W-1:0]  c_idx, t_idx;
  logic [PRIO_W-1:0] c_prio, t_prio;

  assign ack_take = ack_i & fresh & c_found;
  assign change   = (|raise_i) | ack_take;

  hpi_pend #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .raise_i   (raise_i),
    .clr_en_i  (ack_take),
    .clr_idx_i (c_idx),
    .pend_o    (pend_o)
  );

  hpi_tree #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_tree (
    .req_i   (pend_o),
    .prio_i  (prio_i),
    .found_o (t_found),
    .idx_o   (t_idx),
    .prio_o  (t_prio)
  );

  hpi_cache #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_cache (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .change_i (change),
    .found_i  (t_found),
    .idx_i    (t_idx),
    .prio_i   (t_prio),
    .fresh_o  (fresh),
    .found_o  (c_found),
    .idx_o    (c_idx),
    .prio_o   (c_prio)
  );

  assign busy_o      = ~fresh;
  assign sel_valid_o = fresh & c_found;
  assign sel_idx_o   = sel_valid_o ? c_idx : '1;
  assign sel_prio_o  = sel_valid_o ? c_prio : '0;
endmodule

// File: rtl/hpi_select_chk.sv
module hpi_select_chk #(
  parameter int unsigned NUM_SRC = hpi_pkg::SRC_N,
  parameter int unsigned PRIO_W  = hpi_pkg::PRIO_W,
  localparam int unsigned IDX_W  = $clog2(NUM_SRC)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] raise_i,
  input logic               ack_i,
  input logic [IDX_W-1:0]   sel_idx_o,
  input logic               sel_valid_o,
  input logic [PRIO_W-1:0]  sel_prio_o,
  input logic               busy_o,
  input logic [NUM_SRC-1:0] pend_o
);
  p_none_ones_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_valid_o |-> (sel_idx_o == '1 && sel_prio_o == '0));

  p_sel_raised_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_valid_o |-> pend_o[sel_idx_o]);

  p_busy_hides_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !sel_valid_o);

  p_raise_stale_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|raise_i) |=> busy_o);

  p_settle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && raise_i == '0) |=> !busy_o);

  p_raise_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|raise_i) |=> ((pend_o & $past(raise_i)) == $past(raise_i)));

  p_ack_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && sel_valid_o && !raise_i[sel_idx_o]) |=> !pend_o[$past(sel_idx_o)]);

  p_ack_stale_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && sel_valid_o) |=> busy_o);

  p_ack_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !sel_valid_o && raise_i == '0) |=> (pend_o == $past(pend_o)));

  p_ack_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !busy_o && !sel_valid_o && raise_i == '0) |=> !busy_o);

  p_keep_raise_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && sel_valid_o && raise_i[sel_idx_o]) |=> pend_o[$past(sel_idx_o)]);

  p_hold_sel_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_valid_o && !ack_i && raise_i == '0) |=>
      (sel_valid_o && $stable(sel_idx_o) && $stable(sel_prio_o)));
endmodule

bind hpi_select hpi_select_chk #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .raise_i     (raise_i),
  .ack_i       (ack_i),
  .sel_idx_o   (sel_idx_o),
  .sel_valid_o (sel_valid_o),
  .sel_prio_o  (sel_prio_o),
  .busy_o      (busy_o),
  .pend_o      (pend_o)
);

// File: tb/hpi_select_test.sv
`timescale 1ns/1ps
module hpi_select_test;
  localparam int N  = 64;
  localparam int PW = 5;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N-1:0]    raise = '0;
  logic [N*PW-1:0] prio_flat;
  logic            ack = 1'b0;
  logic [5:0]      sel_idx;
  logic            sel_valid;
  logic [PW-1:0]   sel_prio;
  logic            busy;
  logic [N-1:0]    pend;

  logic [PW-1:0]   pr [N];
  logic [N-1:0]    exp_pend = '0;
  logic [PW-1:0]   shown_pr [N];   // priorities as of the last refill
  int total = 0;
  int fails = 0;
  logic [31:0] lfsr = 32'h1d2c_3b4a;

  always #2.5 clk = ~clk;

  always_comb
    for (int k = 0; k < N; k++) prio_flat[k*PW +: PW] = pr[k];

  hpi_select uut (
    .clk_i(clk), .rst_ni(rst_n), .raise_i(raise), .prio_i(prio_flat),
    .ack_i(ack), .sel_idx_o(sel_idx), .sel_valid_o(sel_valid),
    .sel_prio_o(sel_prio), .busy_o(busy), .pend_o(pend)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int model_best(input logic [N-1:0] p);
    int best = -1;
    int bp = -1;
    for (int k = 0; k < N; k++)
      if (p[k] && int'(shown_pr[k]) > bp) begin
        best = k;
        bp = int'(shown_pr[k]);
      end
    return best;
  endfunction

  task automatic snap_prio();
    for (int k = 0; k < N; k++) shown_pr[k] = pr[k];
  endtask

  task automatic check_sel(input string req);
    int b = model_best(exp_pend);
    chk(req, "busy", 64'(busy), 64'd0);
    chk(req, "pend", pend, exp_pend);
    if (b < 0) begin
      chk(req, "valid", 64'(sel_valid), 64'd0);
      chk(req, "idx", 64'(sel_idx), 64'h3f);
      chk(req, "prio", 64'(sel_prio), 64'd0);
    end else begin
      chk(req, "valid", 64'(sel_valid), 64'd1);
      chk(req, "idx", 64'(sel_idx), 64'(b));
      chk(req, "prio", 64'(sel_prio), 64'(shown_pr[b]));
    end
  endtask

  task automatic do_raise(input logic [N-1:0] m, input string req);
    raise = m;
    step();
    raise = '0;
    exp_pend |= m;
    chk("R3", "busy after raise", 64'(busy), 64'd1);
    chk("R3", "valid while stale", 64'(sel_valid), 64'd0);
    snap_prio();
    step();
    check_sel(req);
  endtask

  task automatic do_ack(input string req);
    int b = model_best(exp_pend);
    ack = 1'b1;
    step();
    ack = 1'b0;
    if (b >= 0) exp_pend[b] = 1'b0;
    chk("R8", "busy after ack", 64'(busy), 64'd1);
    chk("R8", "bit cleared", pend, exp_pend);
    snap_prio();
    step();
    check_sel(req);
  endtask

  task automatic drain(input string req);
    for (int g = 0; g < N + 1 && exp_pend != '0; g++) do_ack(req);
  endtask

  task automatic t_reset();
    chk("R1", "pend", pend, '0);
    chk("R1", "valid", 64'(sel_valid), 64'd0);
    chk("R1", "idx", 64'(sel_idx), 64'h3f);
    chk("R1", "prio", 64'(sel_prio), 64'd0);
    chk("R1", "busy", 64'(busy), 64'd0);
  endtask

  task automatic t_single();
    pr[10] = 5'd3;
    do_raise(64'(1) << 10, "R2");
    drain("R7");
  endtask

  task automatic t_highest();
    pr[5] = 5'd2; pr[40] = 5'd9; pr[63] = 5'd7;
    do_raise((64'(1) << 5) | (64'(1) << 40) | (64'(1) << 63), "R4");
    chk("R12", "top prio", 64'(sel_prio), 64'd9);
    drain("R4");
  endtask

  task automatic t_tie();
    pr[20] = 5'd31; pr[12] = 5'd31; pr[50] = 5'd31;
    do_raise((64'(1) << 20) | (64'(1) << 50), "R5");
    do_raise(64'(1) << 12, "R5");
    chk("R5", "lowest index wins", 64'(sel_idx), 64'd12);
    drain("R5");
  endtask

  task automatic t_zero();
    pr[33] = 5'd0;
    do_raise(64'(1) << 33, "R6");
    chk("R6", "prio 0 selected", 64'(sel_idx), 64'd33);
    drain("R7");
  endtask

  task automatic t_ack_ignored();
    // ack with nothing raised
    ack = 1'b1;
    step();
    ack = 1'b0;
    chk("R9", "no stale on empty ack", 64'(busy), 64'd0);
    chk("R9", "pend on empty ack", pend, '0);
    // ack in the stale cycle right after a raise
    pr[7] = 5'd4;
    raise = 64'(1) << 7;
    step();
    raise = '0;
    exp_pend[7] = 1'b1;
    snap_prio();
    ack = 1'b1;
    step();
    ack = 1'b0;
    chk("R9", "pend after busy ack", pend, exp_pend);
    chk("R9", "settled after busy ack", 64'(busy), 64'd0);
    check_sel("R9");
  endtask

  task automatic t_raise_and_ack();
    // source 7 is selected here
    raise = 64'(1) << 7;
    ack = 1'b1;
    step();
    raise = '0;
    ack = 1'b0;
    chk("R10", "bit kept", 64'(pend[7]), 64'd1);
    step();
    check_sel("R10");
  endtask

  task automatic t_prio_change();
    pr[7] = 5'd20;
    step();
    step();
    chk("R11", "prio unchanged", 64'(sel_prio), 64'd4);
    chk("R11", "still valid", 64'(sel_valid), 64'd1);
    pr[2] = 5'd1;
    do_raise(64'(1) << 2, "R11");
    chk("R11", "new prio taken", 64'(sel_prio), 64'd20);
    drain("R8");
  endtask

  task automatic t_random();
    for (int r = 0; r < 40; r++) begin
      for (int k = 0; k < N; k++) begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        pr[k] = {2'b00, lfsr[2:0]};   // narrow range forces ties
      end
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      do_raise({lfsr, lfsr ^ 32'ha5a5_0f0f}, "R4");
      for (int a = 0; a < 3; a++) do_ack("R5");
    end
    drain("R8");
  endtask

  initial begin
    for (int k = 0; k < N; k++) pr[k] = '0;
    snap_prio();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    t_reset();
    t_single();
    t_highest();
    t_tie();
    t_zero();
    t_ack_ignored();
    t_raise_and_ack();
    t_prio_change();
    t_random();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule